// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends bytes over a single serial line using NRZ framing. Each frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. The block computes no parity. Software writes a byte into a one-entry holding buffer. The buffer passes the byte to a transmit shift register only when the shift register is free. It is also free at the exact bit-clock edge where a stop bit finishes, so frames can run back to back with no gap.

An 8-bit reload value sets the tick rate of the rate generator. A rate-select input sets each bit time to either 16 or 64 ticks. A buffer-empty flag signals that software may write the next byte. Only a new write clears this flag. An interrupt output is this flag gated by an enable input. A separate status output reports when the shift register is empty. When the transmit enable drops, any frame in progress is abandoned and the output driver is released.

Top module: `utx_top`

## Requirements
- R1: In 8-bit mode a frame is a start bit of 0, then `wr_data` bits 0 to 7 in that order, then a stop bit of 1. Each bit lasts one bit time.
- R2: When `nine_bit_mode` was 1 at the moment of transfer, a ninth data bit follows bit 7. This bit is the value of `bit9_in` sampled in the transfer cycle, not the value at the time of the write.
- R3: The rate generator emits one tick every `rate_reload+1` clock cycles. A bit lasts 16 ticks when `rate_fast`=1 and 64 ticks when `rate_fast`=0. A `rate_load` pulse takes the new reload value and restarts the count.
- R4: A byte moves from the holding buffer to the shift register in the cycle after it is written, when the shift register is empty and transmit is enabled. While a frame is being sent, the byte stays in the buffer and `buf_empty` stays 0.
- R5: `buf_empty` is 0 out of reset. It goes to 0 in the cycle after a write. It goes to 1 on each transfer. It also goes to 1 when `tx_enable` rises while the buffer is empty. No other input clears it.
- R6: `shift_empty` is 1 whenever no frame is loaded or being sent.
- R7: A loaded frame begins its start bit only on a bit-clock edge. A byte written while `tx_enable`=0 stays in the buffer, with the line inactive, until `tx_enable` is set. It is then sent.
- R8: If the buffer holds data when a stop bit ends, the next start bit follows at once, with no idle bit time.
- R9: When `tx_enable` goes to 0, the frame in progress is aborted, `shift_empty` is 1 and `ser_oe` is 0 one cycle later. The holding buffer keeps its contents.
- R10: `ser_oe` is 1 only when both `port_enable` and `tx_enable` are 1. `ser_out` is 1 when no frame is being sent.
- R11: `irq` is 1 exactly when `buf_empty` is 1 and `irq_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_reload | input | 8 | Reload value for the rate generator |
| rate_load | input | 1 | Strobe that takes `rate_reload` and restarts the generator |
| rate_fast | input | 1 | 1: 16 ticks per bit, 0: 64 ticks per bit |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| bit9_in | input | 1 | Ninth data bit, sampled at transfer |
| nine_bit_mode | input | 1 | Selects 9 data bits |
| tx_enable | input | 1 | Transmit enable; dropping it aborts the frame |
| port_enable | input | 1 | Serial port enable, gates the output driver |
| irq_enable | input | 1 | Interrupt enable |
| ser_out | output | 1 | Serial line value |
| ser_oe | output | 1 | Output-enable for the serial line |
| buf_empty | output | 1 | Holding-buffer-empty flag |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Shift register empty status |

## Verification
The assertions assume that `rate_load` is not pulsed in the middle of a frame. A change of rate during a frame would legally stretch or shorten a bit. The tick-spacing property also assumes that the reload value stays constant between load strobes. The stimulus changes rate settings only while the transmitter is idle. It writes a second byte only after the previous transfer has emptied the buffer, so no pending byte is ever overwritten.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_ARMED = 2'd1,
    SH_SEND  = 2'd2
  } sh_state_t;

  // bit times in one frame: start + data + stop
  function automatic int frame_bits(input logic nine, input int data_w);
    return data_w + 2 + (nine ? 1 : 0);
  endfunction

  // generator ticks in one bit time
  function automatic int bit_ticks(input logic fast, input int fast_t, input int slow_t);
    return fast ? fast_t : slow_t;
  endfunction

endpackage

// File: rtl/utx_rate_gen.sv
module utx_rate_gen #(
  parameter int RELOAD_W   = 8,
  parameter int FAST_TICKS = 16,
  parameter int SLOW_TICKS = 64,
  localparam int SUB_W     = $clog2(SLOW_TICKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] reload_in,
  input  logic                load,
  input  logic                fast,
  output logic                tick,
  output logic                bit_edge
);
  import utx_pkg::*;

  logic [RELOAD_W-1:0] reload_q;
  logic [RELOAD_W-1:0] cnt;
  logic [SUB_W-1:0]    sub;
  logic [SUB_W-1:0]    sub_last;

  assign tick     = (cnt == '0);
  assign sub_last = SUB_W'(bit_ticks(fast, FAST_TICKS, SLOW_TICKS) - 1);
  assign bit_edge = tick && (sub >= sub_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt      <= '0;
      sub      <= '0;
    end else if (load) begin
      reload_q <= reload_in;
      cnt      <= reload_in;
      sub      <= '0;
    end else if (tick) begin
      cnt <= reload_q;
      sub <= bit_edge ? '0 : sub + 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload_q != '0 && !load) |=> !tick); // R3

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
  parameter int DATA_W  = 8,
  localparam int FRAME_W = DATA_W + 3,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              bit_edge,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              bit9,
  input  logic              nine,
  output logic              xfer,
  output logic              line,
  output logic              empty,
  output logic              sending
);
  import utx_pkg::*;

  sh_state_t          state;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic               frame_end;

  function automatic logic [FRAME_W-1:0] build_frame(
      input logic [DATA_W-1:0] d, input logic b9, input logic n9);
    return {1'b1, (n9 ? b9 : 1'b1), d, 1'b0};
  endfunction

  assign frame_end = (state == SH_SEND) && bit_edge && (cnt == CNT_W'(1));
  assign xfer      = run && hold_valid && ((state == SH_IDLE) || frame_end);
  assign sending   = (state == SH_SEND);
  assign empty     = (state == SH_IDLE);
  assign line      = sending ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      sh    <= '1;
      cnt   <= '0;
    end else if (!run) begin
      state <= SH_IDLE;
      sh    <= '1;
      cnt   <= '0;
    end else if (xfer) begin
      sh    <= build_frame(hold_data, bit9, nine);
      cnt   <= CNT_W'(frame_bits(nine, DATA_W));
      state <= (state == SH_IDLE) ? SH_ARMED : SH_SEND;
    end else begin
      case (state)
        SH_ARMED: if (bit_edge) state <= SH_SEND;
        SH_SEND: if (bit_edge) begin
          if (cnt == CNT_W'(1)) begin
            state <= SH_IDLE;
            sh    <= '1;
            cnt   <= '0;
          end else begin
            sh  <= {1'b1, sh[FRAME_W-1:1]};
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> $past(bit_edge)); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> empty); // R9
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> line); // R10

endmodule

// File: rtl/utx_top.sv
module utx_top #(
  parameter int RELOAD_W   = 8,
  parameter int DATA_W     = 8,
  parameter int FAST_TICKS = 16,
  parameter int SLOW_TICKS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] rate_reload,
  input  logic                rate_load,
  input  logic                rate_fast,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                bit9_in,
  input  logic                nine_bit_mode,
  input  logic                tx_enable,
  input  logic                port_enable,
  input  logic                irq_enable,
  output logic                ser_out,
  output logic                ser_oe,
  output logic                buf_empty,
  output logic                irq,
  output logic                shift_empty
);

  logic              tick;
  logic              bit_edge;
  logic              xfer;
  logic              sending;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              flag_q;
  logic              tx_en_q;
  logic              en_rise;

  utx_rate_gen #(
    .RELOAD_W(RELOAD_W), .FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .reload_in(rate_reload), .load(rate_load),
    .fast(rate_fast), .tick(tick), .bit_edge(bit_edge)
  );

  utx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(tx_enable), .bit_edge(bit_edge),
    .hold_valid(hold_valid), .hold_data(hold_data), .bit9(bit9_in),
    .nine(nine_bit_mode), .xfer(xfer), .line(ser_out), .empty(shift_empty),
    .sending(sending)
  );

  assign en_rise = tx_enable && !tx_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      flag_q     <= 1'b0;
      tx_en_q    <= 1'b0;
    end else begin
      tx_en_q <= tx_enable;
      if (wr_en) begin
        hold_valid <= 1'b1;
        hold_data  <= wr_data;
      end else if (xfer) begin
        hold_valid <= 1'b0;
      end
      if (wr_en)                       flag_q <= 1'b0;
      else if (xfer)                   flag_q <= 1'b1;
      else if (en_rise && !hold_valid) flag_q <= 1'b1;
    end
  end

  assign buf_empty = flag_q;
  assign irq       = flag_q && irq_enable;
  assign ser_oe    = port_enable && tx_enable;

  AST_WR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty); // R5
  AST_XFER_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_en) |=> buf_empty); // R4
  AST_BUSY_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && hold_valid && !xfer && !wr_en) |=> !buf_empty); // R4

endmodule

// File: tb/utx_top_tb.sv
module utx_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate_reload = '0;
  logic       rate_load = 1'b0, rate_fast = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit9_in = 1'b0, nine_bit_mode = 1'b0;
  logic       tx_enable = 1'b0, port_enable = 1'b0, irq_enable = 1'b0;
  logic       ser_out, ser_oe, buf_empty, irq, shift_empty;

  int checks = 0;
  int bad = 0;
  int bitc = 16;

  always #4 clk = ~clk;

  utx_top u_dut (
    .clk(clk), .rst_n(rst_n), .rate_reload(rate_reload), .rate_load(rate_load),
    .rate_fast(rate_fast), .wr_en(wr_en), .wr_data(wr_data), .bit9_in(bit9_in),
    .nine_bit_mode(nine_bit_mode), .tx_enable(tx_enable), .port_enable(port_enable),
    .irq_enable(irq_enable), .ser_out(ser_out), .ser_oe(ser_oe),
    .buf_empty(buf_empty), .irq(irq), .shift_empty(shift_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_rate(input logic [7:0] rl, input logic fast);
    rate_reload = rl; rate_fast = fast; rate_load = 1'b1;
    cyc(1);
    rate_load = 1'b0;
    bitc = (int'(rl) + 1) * (fast ? 16 : 64);
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic wait_low(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if (ser_out === 1'b0) begin seen = 1'b1; break; end
      cyc(1);
    end
  endtask

  // expected bits are LSB first in exp
  task automatic recv(input int n, input logic [63:0] exp, input string req);
    bit seen;
    int errs = 0;
    wait_low(seen);
    chk(seen, req, "start bit seen", int'(seen), 1);
    if (!seen) return;
    cyc(bitc / 2);
    for (int i = 0; i < n; i++) begin
      if (ser_out !== exp[i]) begin
        errs++;
        $display("FAIL %s bit %0d: actual=%0d expected=%0d", req, i, ser_out, exp[i]);
      end
      if (i < n - 1) cyc(bitc);
    end
    checks++;
    if (errs != 0) bad++;
  endtask

  function automatic logic [63:0] fr8(input logic [7:0] d);
    return {54'd0, 1'b1, d, 1'b0};
  endfunction

  function automatic logic [63:0] fr9(input logic [7:0] d, input logic b9);
    return {53'd0, 1'b1, b9, d, 1'b0};
  endfunction

  task automatic wait_idle(input string req);
    int i;
    for (i = 0; i < 40000; i++) begin
      if (shift_empty === 1'b1) break;
      cyc(1);
    end
    chk(shift_empty === 1'b1, req, "shifter returns to empty", int'(shift_empty), 1);
  endtask

  task automatic t_reset;
    chk(buf_empty === 1'b0, "R5", "flag after reset", int'(buf_empty), 0);
    chk(shift_empty === 1'b1, "R6", "shift_empty after reset", int'(shift_empty), 1);
    chk(ser_oe === 1'b0, "R10", "oe after reset", int'(ser_oe), 0);
    chk(irq === 1'b0, "R11", "irq after reset", int'(irq), 0);
  endtask

  task automatic t_enable;
    port_enable = 1'b1; tx_enable = 1'b1;
    cyc(1);
    chk(buf_empty === 1'b1, "R5", "flag set on enable rise", int'(buf_empty), 1);
    chk(ser_oe === 1'b1, "R10", "oe with both enables", int'(ser_oe), 1);
    chk(ser_out === 1'b1, "R10", "idle line high", int'(ser_out), 1);
    irq_enable = 1'b1; cyc(1);
    chk(irq === 1'b1, "R11", "irq with enable", int'(irq), 1);
    irq_enable = 1'b0; cyc(1);
    chk(irq === 1'b0, "R11", "irq masked", int'(irq), 0);
    cyc(5);
    chk(buf_empty === 1'b1, "R5", "flag holds without write", int'(buf_empty), 1);
  endtask

  task automatic t_basic;
    write_byte(8'hA5);
    chk(buf_empty === 1'b0, "R5", "flag cleared by write", int'(buf_empty), 0);
    cyc(1);
    chk(buf_empty === 1'b1, "R4", "flag set by transfer", int'(buf_empty), 1);
    chk(shift_empty === 1'b0, "R6", "shifter loaded", int'(shift_empty), 0);
    recv(10, fr8(8'hA5), "R1");
    wait_idle("R6");
    write_byte(8'h3E);
    recv(10, fr8(8'h3E), "R1");
    wait_idle("R6");
  endtask

  task automatic t_width(input logic [7:0] rl, input logic fast);
    bit seen;
    int lowc = 0;
    set_rate(rl, fast);
    cyc(2);
    write_byte(8'h01);
    wait_low(seen);
    while (ser_out === 1'b0 && lowc < 40000) begin lowc++; cyc(1); end
    chk(lowc == bitc, "R3", "start bit length in cycles", lowc, bitc);
    wait_idle("R6");
  endtask

  task automatic t_nine;
    nine_bit_mode = 1'b1; bit9_in = 1'b1;
    write_byte(8'h3C);
    recv(11, fr9(8'h3C, 1'b1), "R2");
    wait_idle("R6");
    bit9_in = 1'b0;
    write_byte(8'hC3);
    cyc(2);
    bit9_in = 1'b1;
    recv(11, fr9(8'hC3, 1'b0), "R2");
    wait_idle("R6");
    nine_bit_mode = 1'b0; bit9_in = 1'b0;
  endtask

  task automatic t_b2b;
    logic [63:0] e;
    write_byte(8'h55);
    cyc(2);
    write_byte(8'h0F);
    cyc(5);
    chk(buf_empty === 1'b0, "R4", "byte held while busy", int'(buf_empty), 0);
    e = (fr8(8'h0F) << 10) | fr8(8'h55);
    recv(20, e, "R8");
    wait_idle("R6");
  endtask

  task automatic t_pre_enable;
    tx_enable = 1'b0; cyc(2);
    write_byte(8'h81);
    cyc(100);
    chk(shift_empty === 1'b1, "R7", "no transfer while disabled", int'(shift_empty), 1);
    chk(ser_oe === 1'b0, "R7", "line inactive while disabled", int'(ser_oe), 0);
    chk(buf_empty === 1'b0, "R7", "byte still pending", int'(buf_empty), 0);
    tx_enable = 1'b1;
    recv(10, fr8(8'h81), "R7");
    wait_idle("R6");
  endtask

  task automatic t_abort;
    bit seen;
    write_byte(8'hF0);
    wait_low(seen);
    cyc(3 * bitc);
    write_byte(8'h11);
    tx_enable = 1'b0;
    cyc(1);
    chk(shift_empty === 1'b1, "R9", "shifter reset by abort", int'(shift_empty), 1);
    chk(ser_oe === 1'b0, "R9", "driver released by abort", int'(ser_oe), 0);
    chk(buf_empty === 1'b0, "R9", "buffer kept through abort", int'(buf_empty), 0);
    cyc(20);
    tx_enable = 1'b1;
    recv(10, fr8(8'h11), "R9");
    wait_idle("R6");
  endtask

  task automatic t_port;
    port_enable = 1'b0; cyc(1);
    chk(ser_oe === 1'b0, "R10", "oe off without port enable", int'(ser_oe), 0);
    port_enable = 1'b1; cyc(1);
    chk(ser_oe === 1'b1, "R10", "oe back on", int'(ser_oe), 1);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    set_rate(8'd0, 1'b1);
    t_enable();
    t_basic();
    t_width(8'd3, 1'b0);
    t_width(8'd3, 1'b1);
    set_rate(8'd1, 1'b1);
    t_nine();
    t_b2b();
    t_pre_enable();
    t_abort();
    t_port();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule